// File: doc/BRIEF.md
# Threshold Cell Selector with Occupancy Bitmap

The block takes the per-cell energy results of one processing slice, up to 512 cells per bunch crossing. They arrive one cell per clock in ascending index order. Each energy is compared against a cut of twice that cell's noise level, supplied alongside it. A cell passes when its signed energy is strictly greater than the cut. For every crossing the block records which cells passed in a 512-bit occupancy map, and it keeps the energies of the passing cells in a two-slot store.

When a crossing is complete, it is sent as one frame on a valid/ready stream of 32-bit words. The frame has a header word, then the occupancy map as sixteen words, then the selected energies. The number of energies per frame is capped at a budget sized for about 30% of the cells. This keeps a burst of activity from overrunning the downstream link. The map always shows every cell that passed, including cells whose energy was cut by the budget.

If the output stalls so long that both slots still hold unsent frames when a new crossing begins, that new crossing is discarded whole and counted.

Top module: `hit_select_top`

## Requirements
- R1: While reset is held and on the cycle after it, out_valid is 0 and drop_count is 0.
- R2: A cell passes only when its energy, read as a signed 16-bit value, is strictly greater than twice its unsigned 15-bit noise input. An energy equal to the cut does not pass, and a negative energy never passes.
- R3: A frame is word 0 (header), then words 1 to 16 (occupancy map), then one word per sent energy. Bit j of map word k belongs to cell 32k+j. out_last is 1 on the final word only.
- R4: The header holds the crossing number in bits 31:16, the overflow flag in bit 15 and the number of energies sent in bits 14:0. The crossing number starts at 0 after reset and advances once per crossing, dropped crossings included.
- R5: Energy words follow in ascending cell index. Each carries the 16-bit energy in bits 15:0, with bits 31:16 zero.
- R6: At most 153 energies are sent per frame. When more than 153 cells pass, the first 153 by index are sent, the overflow flag is 1, and the map still marks every passing cell. When exactly 153 pass, the flag is 0.
- R7: Map bits for cell positions not delivered in a crossing read as 0, whatever earlier crossings held there.
- R8: A crossing whose first cell arrives while two complete frames are still unsent is discarded. No frame is produced for it and drop_count increments by one. Frames are always sent whole and in crossing order.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.
- R10: A crossing ends at the cell with in_last set, or at cell index 511 if in_last was never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One cell result present this cycle |
| in_last | input | 1 | This cell is the last of the crossing |
| in_energy | input | 16 | Signed cell energy |
| in_noise | input | 15 | Unsigned cell noise level; the cut is twice this |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Frame word |
| out_last | output | 1 | Final word of a frame |
| drop_count | output | 16 | Number of discarded crossings |

## Verification
The checker relies on one property of the input side: cells of a crossing arrive gap-free in index order, and each crossing is closed by in_last or by the index limit before the next one starts. The bench always drives cells back to back, with in_valid dropping only between crossings. The checker also relies on the downstream side keeping to the valid/ready rule, so that a frame boundary can be tracked from accepted out_last words. Under these conditions the header-count limits and the hold rule can be checked at the ports. Every crossing in the bench is driven completely, whether out_ready is held low, toggled or held high.

// File: rtl/hit_select_pkg.sv
package hit_select_pkg;
  localparam int WORD_W    = 32;
  localparam int XING_W    = 16;
  localparam int HCNT_W    = 15;

  function automatic logic [WORD_W-1:0] mk_header(
    input logic [XING_W-1:0] xing,
    input logic              ovf,
    input logic [HCNT_W-1:0] cnt
  );
    return {xing, ovf, cnt};
  endfunction
endpackage

// File: rtl/thr_cmp.sv
module thr_cmp #(
  parameter int EW = 16
) (
  input  logic [EW-1:0] energy,
  input  logic [EW-2:0] noise,
  output logic          pass
);
  logic signed [EW:0] e_ext;
  logic signed [EW:0] cut;

  always_comb begin
    e_ext = $signed({energy[EW-1], energy});
    cut   = $signed({1'b0, noise, 1'b0});
    pass  = e_ext > cut;
  end
endmodule

// File: rtl/sel_store.sv
module sel_store #(
  parameter int EW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW:0]   waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW:0]   raddr,
  output logic [EW-1:0] rdata
);
  localparam int DEPTH = 2 ** (AW + 1);

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sel_capture.sv
module sel_capture #(
  parameter int NCELLS = 512,
  parameter int EW     = 16,
  parameter int CAP    = 153,
  parameter int XW     = 16,
  parameter int DW     = 16,
  localparam int IW    = $clog2(NCELLS),
  localparam int CW    = $clog2(CAP + 1),
  localparam int AW    = $clog2(CAP)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       in_last,
  input  logic [EW-1:0]              in_energy,
  input  logic                       pass,
  input  logic                       clr_v,
  input  logic                       clr_b,
  output logic [1:0]                 full,
  output logic [1:0][NCELLS-1:0]     bm,
  output logic [1:0][CW-1:0]         hcnt,
  output logic [1:0]                 hovf,
  output logic [1:0][XW-1:0]         hxing,
  output logic                       we,
  output logic [AW:0]                waddr,
  output logic [EW-1:0]              wdata,
  output logic [DW-1:0]              drops
);
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt, base, cnt_n;
  logic          ovf, ovf_n, dropping, drop_c, cb;
  logic          first, last_e, room, take;
  logic [XW-1:0] xing;

  always_comb begin
    first  = (idx == '0);
    last_e = in_last || (idx == IW'(NCELLS - 1));
    drop_c = first ? full[cb] : dropping;
    base   = first ? '0 : cnt;
    room   = base < CW'(CAP);
    take   = in_valid && pass && !drop_c && room;
    ovf_n  = (first ? 1'b0 : ovf) | (pass && !room);
    cnt_n  = base + CW'(take);
    we     = take;
    waddr  = {cb, base[AW-1:0]};
    wdata  = in_energy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      cnt      <= '0;
      ovf      <= 1'b0;
      dropping <= 1'b0;
      cb       <= 1'b0;
      full     <= '0;
      xing     <= '0;
      drops    <= '0;
    end else begin
      if (clr_v) full[clr_b] <= 1'b0;
      if (in_valid) begin
        dropping <= drop_c;
        cnt      <= cnt_n;
        ovf      <= ovf_n;
        if (!drop_c) begin
          if (first) bm[cb] <= {{(NCELLS-1){1'b0}}, pass};
          else       bm[cb][idx] <= pass;
        end
        if (last_e) begin
          idx  <= '0;
          xing <= xing + 1'b1;
          if (drop_c) begin
            drops <= drops + 1'b1;
          end else begin
            full[cb]  <= 1'b1;
            hcnt[cb]  <= cnt_n;
            hovf[cb]  <= ovf_n;
            hxing[cb] <= xing;
            cb        <= ~cb;
          end
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frame_emit.sv
module frame_emit
  import hit_select_pkg::*;
#(
  parameter int NCELLS = 512,
  parameter int EW     = 16,
  parameter int CAP    = 153,
  localparam int CW    = $clog2(CAP + 1),
  localparam int AW    = $clog2(CAP),
  localparam int NBW   = NCELLS / WORD_W,
  localparam int BW    = $clog2(NBW),
  localparam int PW    = $clog2(NBW + CAP + 2)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 full,
  input  logic [1:0][NCELLS-1:0]     bm,
  input  logic [1:0][CW-1:0]         hcnt,
  input  logic [1:0]                 hovf,
  input  logic [1:0][XING_W-1:0]     hxing,
  input  logic [EW-1:0]              rdata,
  output logic [AW:0]                raddr,
  output logic                       clr_v,
  output logic                       clr_b,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic [WORD_W-1:0]          out_data,
  output logic                       out_last
);
  logic          eb, eb_n, ld, lastw;
  logic [PW-1:0] pos, pos_n, eoff, wtmp;
  logic [BW-1:0] wsel;
  logic [AW-1:0] ridx;
  logic [WORD_W-1:0] word;

  always_comb begin
    ld    = full[eb] && (!out_valid || out_ready);
    lastw = (pos == PW'(NBW) + PW'(hcnt[eb]));
    pos_n = ld ? (lastw ? '0 : pos + 1'b1) : pos;
    eb_n  = (ld && lastw) ? ~eb : eb;
    clr_v = ld && lastw;
    clr_b = eb;
    eoff  = pos_n - PW'(NBW + 1);
    ridx  = (pos_n > PW'(NBW)) ? eoff[AW-1:0] : '0;
    raddr = {eb_n, ridx};
    wtmp  = pos - 1'b1;
    wsel  = wtmp[BW-1:0];
    if (pos == '0)
      word = mk_header(hxing[eb], hovf[eb], HCNT_W'(hcnt[eb]));
    else if (pos <= PW'(NBW))
      word = bm[eb][wsel*WORD_W +: WORD_W];
    else
      word = {{(WORD_W-EW){1'b0}}, rdata};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eb        <= 1'b0;
      pos       <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      if (ld) begin
        out_valid <= 1'b1;
        out_data  <= word;
        out_last  <= lastw;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      pos <= pos_n;
      eb  <= eb_n;
    end
  end
endmodule

// File: rtl/hit_select_top.sv
module hit_select_top
  import hit_select_pkg::*;
#(
  parameter int NCELLS = 512,
  parameter int EW     = 16,
  parameter int CAP    = 153,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [EW-1:0]     in_energy,
  input  logic [EW-2:0]     in_noise,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic [DW-1:0]     drop_count
);
  localparam int CW = $clog2(CAP + 1);
  localparam int AW = $clog2(CAP);

  logic                   pass, clr_v, clr_b, we;
  logic [1:0]             full, hovf;
  logic [1:0][NCELLS-1:0] bm;
  logic [1:0][CW-1:0]     hcnt;
  logic [1:0][XING_W-1:0] hxing;
  logic [AW:0]            waddr, raddr;
  logic [EW-1:0]          wdata, rdata;

  thr_cmp #(.EW(EW)) u_cmp (
    .energy(in_energy), .noise(in_noise), .pass(pass)
  );

  sel_capture #(.NCELLS(NCELLS), .EW(EW), .CAP(CAP), .XW(XING_W), .DW(DW)) u_cap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_energy(in_energy), .pass(pass), .clr_v(clr_v), .clr_b(clr_b),
    .full(full), .bm(bm), .hcnt(hcnt), .hovf(hovf), .hxing(hxing),
    .we(we), .waddr(waddr), .wdata(wdata), .drops(drop_count)
  );

  sel_store #(.EW(EW), .AW(AW)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  frame_emit #(.NCELLS(NCELLS), .EW(EW), .CAP(CAP)) u_emit (
    .clk(clk), .rst(rst), .full(full), .bm(bm), .hcnt(hcnt), .hovf(hovf),
    .hxing(hxing), .rdata(rdata), .raddr(raddr), .clr_v(clr_v), .clr_b(clr_b),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last)
  );
endmodule

// File: rtl/hit_select_chk.sv
module hit_select_chk #(
  parameter int CAP = 153,
  parameter int DW  = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_data,
  input logic          out_last,
  input logic [DW-1:0] drop_count
);
  logic sop;

  always_ff @(posedge clk) begin
    if (rst) sop <= 1'b1;
    else if (out_valid && out_ready) sop <= out_last;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!out_valid && drop_count == '0));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R6
  cap_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sop) |-> (out_data[14:0] <= 15'(CAP)));

  // R6
  ovf_full_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sop && out_data[15]) |-> (out_data[14:0] == 15'(CAP)));

  // R8
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_count == $past(drop_count) || drop_count == $past(drop_count) + 1'b1));

  // R3
  hdr_not_last_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sop) |-> !out_last);
endmodule

bind hit_select_top hit_select_chk #(.CAP(CAP), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .drop_count(drop_count)
);

// File: tb/sim_hit_select_top.sv
module sim_hit_select_top;
  localparam int N   = 512;
  localparam int CAP = 153;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic [15:0] in_energy = '0;
  logic [14:0] in_noise = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_last;
  logic [15:0] drop_count;

  int checks = 0;
  int errors = 0;
  int en [N];
  int nz [N];
  logic [31:0] got [700];
  int          ngot;
  int          last_pos;
  int          last_cnt;

  hit_select_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_energy(in_energy), .in_noise(in_noise), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .drop_count(drop_count)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_xing(input int n, input bit use_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_energy = en[i][15:0];
      in_noise  = nz[i][14:0];
      in_last   = use_last && (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  // rmode 0: always ready, 1: ready two of three cycles, 2: ready one of four
  task automatic collect(input int rmode);
    int cyc = 0;
    bit done = 0;
    ngot = 0; last_pos = -1; last_cnt = 0;
    while (!done) begin
      @(negedge clk);
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 0;
        default: out_ready = (cyc % 4) == 1;
      endcase
      cyc++;
      if (out_valid && out_ready) begin
        if (ngot < 700) got[ngot] = out_data;
        if (out_last) begin last_pos = ngot; last_cnt++; done = 1; end
        ngot++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic recv_check(input string req, input int xn, input int n, input int rmode);
    logic [N-1:0] bmap = '0;
    int elist [CAP];
    int cnt = 0;
    bit ovf = 0;
    int bad;
    for (int i = 0; i < n; i++) begin
      if (en[i] > 2 * nz[i]) begin
        bmap[i] = 1'b1;
        if (cnt < CAP) begin elist[cnt] = en[i]; cnt++; end
        else ovf = 1;
      end
    end
    collect(rmode);
    check({req, " R4"}, "header", got[0], {xn[15:0], ovf, cnt[14:0]});
    bad = 0;
    for (int k = 0; k < 16; k++) if (got[1 + k] != bmap[k*32 +: 32]) bad++;
    check({req, " R3 R2 R7"}, "bitmap mismatching words", bad, 0);
    bad = 0;
    for (int k = 0; k < cnt; k++) if (got[17 + k] != 32'(elist[k])) bad++;
    check({req, " R5"}, "energy mismatching words", bad, 0);
    check({req, " R3"}, "frame length", ngot, 17 + cnt);
    check({req, " R3"}, "last position", last_pos, 16 + cnt);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "out_valid in reset", out_valid, 0);
    check("R1", "drop_count in reset", drop_count, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_sparse();
    for (int i = 0; i < N; i++) begin
      nz[i] = i % 50 + 1;
      case (i % 20)
        3:  en[i] = 2 * nz[i] + 1;
        7:  en[i] = 2 * nz[i];
        11: begin nz[i] = 0; en[i] = -5; end
        15: begin nz[i] = 0; en[i] = 0; end
        default: en[i] = nz[i];
      endcase
    end
    send_xing(448, 1);
    recv_check("sparse R2 R7", 0, 448, 0);
  endtask

  task automatic t_burst();
    for (int i = 0; i < N; i++) begin en[i] = 1000 + i; nz[i] = 10; end
    send_xing(N, 1);
    recv_check("burst R6 R9", 1, N, 1);
  endtask

  task automatic t_exact();
    for (int i = 0; i < N; i++) begin
      nz[i] = 20;
      en[i] = (i < 459 && i % 3 == 0) ? 41 + i : 40;
    end
    send_xing(N, 1);
    recv_check("exact R6", 2, N, 2);
  endtask

  task automatic t_short();
    for (int i = 0; i < N; i++) begin en[i] = 3000 - i; nz[i] = 0; end
    send_xing(448, 1);
    recv_check("short R7 R6", 3, 448, 0);
  endtask

  task automatic t_drop();
    for (int i = 0; i < N; i++) begin en[i] = (i % 7 == 0) ? 500 + i : 1; nz[i] = 5; end
    send_xing(200, 1);
    send_xing(200, 1);
    send_xing(200, 1);
    check("R8", "drop_count after third crossing", drop_count, 1);
    recv_check("drop R8 first", 4, 200, 0);
    recv_check("drop R8 second", 5, 200, 1);
    repeat (30) @(negedge clk);
    check("R8", "no frame for dropped crossing", out_valid, 0);
  endtask

  task automatic t_nolast();
    for (int i = 0; i < N; i++) begin en[i] = (i % 5 == 2) ? 77 : -3; nz[i] = 30; end
    send_xing(N, 0);
    recv_check("nolast R10", 7, N, 0);
    for (int i = 0; i < N; i++) begin en[i] = (i % 9 == 0) ? 900 : 0; nz[i] = 1; end
    send_xing(100, 1);
    recv_check("after limit R10", 8, 100, 0);
    check("R8", "drop_count stays", drop_count, 1);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_sparse();
    t_burst();
    t_exact();
    t_short();
    t_drop();
    t_nolast();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule